// File: doc/BRIEF.md
# White Balance Detection Accumulator

This statistics block gathers white-balance evidence from a stream of signed colour-difference samples. Each valid sample is mapped onto two new axes. The first is a red-minus-blue axis. The second is a magenta-minus-green axis. A window test then decides whether the sample lies close enough to neutral to count as white. Only white samples add their two axis values to a pair of frame-long sums and bump a sample counter.

A frame-start strobe ends one frame and begins the next. On that strobe the three running totals are copied into result registers, and the running totals restart. A slow 8-bit host can then read the results over the whole following frame, divide each sum by the count, and steer the red and blue gains toward neutral. The sums clamp at their extremes rather than wrapping, so a long bright frame never produces a value with the wrong sign.

Top module: `wb_stat_accum`

## Requirements
- R1: After reset, res_rb, res_mg and res_count all read zero.
- R2: The red-minus-blue axis value of a sample is ry_in minus by_in (range -511 to +511 for 9-bit inputs).
- R3: The magenta-minus-green axis value is the negated sum of ry_in and by_in, shifted right arithmetically by one (rounded toward minus infinity), so ry_in=7, by_in=0 gives -4.
- R4: A sample is white only when the magnitude of its red-minus-blue value is at most rb_limit and the magnitude of its magenta-minus-green value is at most mg_limit; both limits are inclusive and unsigned.
- R5: A white sample must also have luma_in strictly greater than luma_floor; a sample with luma_in equal to luma_floor is not white.
- R6: Each cycle with sample_valid high and a white sample adds its two axis values to the running sums and adds one to the running count. Samples with sample_valid low, and samples that are not white, leave all totals unchanged.
- R7: res_rb, res_mg and res_count change only on a cycle with frame_start high, and they hold their values between such cycles.
- R8: On a frame_start cycle, the results take the running totals as they stood before that cycle. The running totals restart from zero, and a valid white sample in that same cycle is the first contribution of the new frame.
- R9: Each running sum saturates at +2^23-1 and at -2^23 instead of wrapping. The count saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe: latch totals, start new frame |
| sample_valid | input | 1 | Qualifies the sample inputs this cycle |
| ry_in | input | 9 | Signed R-Y colour-difference sample |
| by_in | input | 9 | Signed B-Y colour-difference sample |
| luma_in | input | 8 | Unsigned luminance of the same pixel |
| rb_limit | input | 10 | Inclusive limit on the red-minus-blue magnitude |
| mg_limit | input | 10 | Inclusive limit on the magenta-minus-green magnitude |
| luma_floor | input | 8 | Luminance must exceed this value |
| res_rb | output | 24 | Latched signed red-minus-blue sum |
| res_mg | output | 24 | Latched signed magenta-minus-green sum |
| res_count | output | 20 | Latched number of white samples |

## Verification
A frame boundary and a white sample can arrive in the same cycle. The results must then report only the frame that is closing, while that sample seeds the new frame. The bench provokes this by raising frame_start together with sample_valid on a white sample whose values are known. It then checks that the count just latched excludes the sample. At the following boundary it checks that the latched count is one and the sums equal that sample's axis values. Saturation is also run to both extremes with enough samples to pass the limit, and the bench confirms that the latched sum sits exactly at the clamp value.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
   parameter int WBS_IN_W   = 9;
   parameter int WBS_LUMA_W = 8;
   parameter int WBS_SUM_W  = 24;
   parameter int WBS_CNT_W  = 20;
endpackage

// File: rtl/wbs_axis_xform.sv
module wbs_axis_xform #(
   parameter int IN_W = 9,
   localparam int AX_W = IN_W + 1
) (
   input  logic signed [IN_W-1:0] ry,
   input  logic signed [IN_W-1:0] by,
   output logic signed [AX_W-1:0] rb_axis,
   output logic signed [AX_W-1:0] mg_axis
);
   logic signed [AX_W-1:0] pair_sum;
   logic signed [AX_W:0]   neg_sum;
   logic signed [AX_W:0]   neg_half;

   always_comb begin
      rb_axis  = AX_W'(ry) - AX_W'(by);
      pair_sum = AX_W'(ry) + AX_W'(by);
      neg_sum  = -((AX_W+1)'(pair_sum));
      neg_half = neg_sum >>> 1;
      mg_axis  = neg_half[AX_W-1:0];
   end
endmodule

// File: rtl/wbs_white_gate.sv
module wbs_white_gate #(
   parameter int AX_W   = 10,
   parameter int LUMA_W = 8
) (
   input  logic signed [AX_W-1:0]   rb_axis,
   input  logic signed [AX_W-1:0]   mg_axis,
   input  logic        [AX_W-1:0]   rb_lim,
   input  logic        [AX_W-1:0]   mg_lim,
   input  logic        [LUMA_W-1:0] luma,
   input  logic        [LUMA_W-1:0] floor_lvl,
   output logic                     is_white
);
   logic signed [AX_W:0] rb_ext, mg_ext;
   logic        [AX_W:0] rb_mag, mg_mag;

   always_comb begin
      rb_ext = (AX_W+1)'(rb_axis);
      mg_ext = (AX_W+1)'(mg_axis);
      rb_mag = $unsigned(rb_ext[AX_W] ? -rb_ext : rb_ext);
      mg_mag = $unsigned(mg_ext[AX_W] ? -mg_ext : mg_ext);
      is_white = (rb_mag <= {1'b0, rb_lim}) &&
                 (mg_mag <= {1'b0, mg_lim}) &&
                 (luma > floor_lvl);
   end
endmodule

// File: rtl/wbs_sat_acc.sv
module wbs_sat_acc #(
   parameter int ACC_W    = 24,
   parameter int DIN_W    = 10,
   parameter bit SATURATE = 1'b1,
   localparam int EXT_W   = ACC_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    restart,
   input  logic                    add_en,
   input  logic signed [DIN_W-1:0] din,
   output logic signed [ACC_W-1:0] acc
);
   localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

   generate
      if (DIN_W >= ACC_W) begin : g_bad_width
         $error("wbs_sat_acc: accumulator must be wider than its input");
      end
   endgenerate

   logic signed [ACC_W-1:0] acc_q, acc_next, add_res;
   logic signed [EXT_W-1:0] sum_ext;

   always_comb sum_ext = EXT_W'(acc_q) + EXT_W'(din);

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (sum_ext[EXT_W-1] != sum_ext[EXT_W-2])
               add_res = sum_ext[EXT_W-1] ? ACC_MIN : ACC_MAX;
            else
               add_res = sum_ext[ACC_W-1:0];
         end
      end else begin : g_wrap
         always_comb add_res = sum_ext[ACC_W-1:0];
      end
   endgenerate

   always_comb begin
      if (restart)
         acc_next = add_en ? ACC_W'(din) : '0;
      else if (add_en)
         acc_next = add_res;
      else
         acc_next = acc_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_next;
   end

   assign acc = acc_q;
endmodule

// File: rtl/wb_stat_accum.sv
module wb_stat_accum #(
   parameter int IN_W   = wbs_pkg::WBS_IN_W,
   parameter int LUMA_W = wbs_pkg::WBS_LUMA_W,
   parameter int SUM_W  = wbs_pkg::WBS_SUM_W,
   parameter int CNT_W  = wbs_pkg::WBS_CNT_W,
   localparam int AX_W  = IN_W + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     frame_start,
   input  logic                     sample_valid,
   input  logic signed [IN_W-1:0]   ry_in,
   input  logic signed [IN_W-1:0]   by_in,
   input  logic        [LUMA_W-1:0] luma_in,
   input  logic        [AX_W-1:0]   rb_limit,
   input  logic        [AX_W-1:0]   mg_limit,
   input  logic        [LUMA_W-1:0] luma_floor,
   output logic signed [SUM_W-1:0]  res_rb,
   output logic signed [SUM_W-1:0]  res_mg,
   output logic        [CNT_W-1:0]  res_count
);
   generate
      if (IN_W < 2 || CNT_W < 1 || SUM_W <= AX_W) begin : g_bad_cfg
         $error("wb_stat_accum: inconsistent width parameters");
      end
   endgenerate

   logic signed [AX_W-1:0]  rb_val, mg_val;
   logic                    white;
   logic                    take;
   logic signed [SUM_W-1:0] acc_rb, acc_mg;
   logic        [CNT_W-1:0] cnt_q;

   wbs_axis_xform #(.IN_W(IN_W)) u_xform (
      .ry(ry_in), .by(by_in), .rb_axis(rb_val), .mg_axis(mg_val)
   );

   wbs_white_gate #(.AX_W(AX_W), .LUMA_W(LUMA_W)) u_gate (
      .rb_axis(rb_val), .mg_axis(mg_val), .rb_lim(rb_limit), .mg_lim(mg_limit),
      .luma(luma_in), .floor_lvl(luma_floor), .is_white(white)
   );

   assign take = sample_valid & white;

   wbs_sat_acc #(.ACC_W(SUM_W), .DIN_W(AX_W), .SATURATE(1'b1)) u_acc_rb (
      .clk(clk), .rst_n(rst_n), .restart(frame_start), .add_en(take),
      .din(rb_val), .acc(acc_rb)
   );

   wbs_sat_acc #(.ACC_W(SUM_W), .DIN_W(AX_W), .SATURATE(1'b1)) u_acc_mg (
      .clk(clk), .rst_n(rst_n), .restart(frame_start), .add_en(take),
      .din(mg_val), .acc(acc_mg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (frame_start)
         cnt_q <= take ? CNT_W'(1) : '0;
      else if (take && cnt_q != '1)
         cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_rb    <= '0;
         res_mg    <= '0;
         res_count <= '0;
      end else if (frame_start) begin
         res_rb    <= acc_rb;
         res_mg    <= acc_mg;
         res_count <= cnt_q;
      end
   end
endmodule

// File: rtl/wbs_checker.sv
module wbs_checker #(
   parameter int SUM_W = 24,
   parameter int CNT_W = 20,
   parameter int AX_W  = 10
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    frame_start,
   input logic                    sample_valid,
   input logic                    take,
   input logic        [CNT_W-1:0] cnt_q,
   input logic signed [SUM_W-1:0] acc_rb,
   input logic signed [AX_W-1:0]  rb_val,
   input logic signed [SUM_W-1:0] res_rb,
   input logic signed [SUM_W-1:0] res_mg,
   input logic        [CNT_W-1:0] res_count
);
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> ($stable(res_count) && $stable(res_rb) && $stable(res_mg)));

   a_r8_latch: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (res_count == $past(cnt_q)));

   a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !take) |=> (cnt_q == '0));

   a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_start && !sample_valid) |=> $stable(cnt_q));

   a_r6_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_start && take && cnt_q != '1) |=> (cnt_q == $past(cnt_q) + 1'b1));

   a_r9_no_pos_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_start && take && !acc_rb[SUM_W-1] && !rb_val[AX_W-1])
      |=> !acc_rb[SUM_W-1]);
endmodule

bind wb_stat_accum wbs_checker #(.SUM_W(SUM_W), .CNT_W(CNT_W), .AX_W(AX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .sample_valid(sample_valid),
   .take(take), .cnt_q(cnt_q), .acc_rb(acc_rb), .rb_val(rb_val),
   .res_rb(res_rb), .res_mg(res_mg), .res_count(res_count)
);

// File: tb/sim_wb_stat_accum.sv
module sim_wb_stat_accum;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 11;
   // ry, by, luma, expected white, expected rb, expected mg
   localparam int VEC [0:NVEC-1][0:5] = '{
      '{ 10,  -5, 50, 1,   15,  -3},
      '{-20,  30, 50, 1,  -50,  -5},
      '{ 60, -40, 50, 1,  100, -10},
      '{ 61, -40, 50, 0,    0,   0},
      '{-60, -60, 50, 1,    0,  60},
      '{-61, -60, 50, 1,   -1,  60},
      '{-62, -61, 50, 0,    0,   0},
      '{  7,   0, 16, 0,    0,   0},
      '{  7,   0, 17, 1,    7,  -4},
      '{  0,   0,200, 1,    0,   0},
      '{-100,  0, 50, 1, -100,  50}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_start = 1'b0, sample_valid = 1'b0;
   logic signed [8:0] ry_in = '0, by_in = '0;
   logic [7:0] luma_in = '0, luma_floor = 8'd16;
   logic [9:0] rb_limit = 10'd100, mg_limit = 10'd60;
   logic signed [23:0] res_rb, res_mg;
   logic [19:0] res_count;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wb_stat_accum u0 (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .sample_valid(sample_valid),
      .ry_in(ry_in), .by_in(by_in), .luma_in(luma_in), .rb_limit(rb_limit),
      .mg_limit(mg_limit), .luma_floor(luma_floor),
      .res_rb(res_rb), .res_mg(res_mg), .res_count(res_count)
   );

   task automatic check(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic step(input bit fs, input bit vld, input int ry, input int by, input int lu);
      frame_start  = fs;
      sample_valid = vld;
      ry_in   = 9'(ry);
      by_in   = 9'(by);
      luma_in = 8'(lu);
      @(posedge clk);
      @(negedge clk);
      frame_start  = 1'b0;
      sample_valid = 1'b0;
   endtask

   task automatic check_res(input string req, input int rb, input int mg, input int cnt);
      check({req, " rb"}, int'(res_rb), rb);
      check({req, " mg"}, int'(res_mg), mg);
      check({req, " count"}, int'(res_count), cnt);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_res("R1 reset", 0, 0, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3 R4 R5: one sample per frame from the vector table
      for (int i = 0; i < NVEC; i++) begin
         step(1'b1, 1'b0, 0, 0, 0);
         step(1'b0, 1'b1, VEC[i][0], VEC[i][1], VEC[i][2]);
         step(1'b1, 1'b0, 0, 0, 0);
         check_res($sformatf("R2/R3/R4/R5 vec%0d", i), VEC[i][4], VEC[i][5], VEC[i][3]);
      end

      // R6: mixed frame, invalid and non-white samples ignored
      step(1'b1, 1'b0, 0, 0, 0);
      step(1'b0, 1'b1, 10, -5, 50);
      step(1'b0, 1'b0, 50, 0, 50);
      step(1'b0, 1'b1, 90, -40, 50);
      step(1'b0, 1'b1, -20, 30, 50);
      step(1'b0, 1'b1, 0, 0, 10);
      step(1'b0, 1'b1, 0, 0, 200);
      step(1'b1, 1'b0, 0, 0, 0);
      check_res("R6 mixed", -35, -8, 3);

      // R7: results hold while a new frame runs
      step(1'b0, 1'b1, 20, 0, 50);
      step(1'b0, 1'b1, 20, 0, 50);
      check_res("R7 hold", -35, -8, 3);

      // R8: frame boundary coincides with a white sample
      step(1'b1, 1'b1, 30, 10, 50);
      check_res("R8 boundary latch", 40, -20, 2);
      step(1'b1, 1'b0, 0, 0, 0);
      check_res("R8 seeded frame", 20, -20, 1);

      // R9: positive saturation
      rb_limit = 10'd1023;
      mg_limit = 10'd1023;
      frame_start = 1'b1;
      sample_valid = 1'b1;
      ry_in = 9'sd255; by_in = -9'sd255; luma_in = 8'd100;
      @(posedge clk); @(negedge clk);
      frame_start = 1'b0;
      repeat (16499) @(posedge clk);
      @(negedge clk);
      sample_valid = 1'b0;
      step(1'b1, 1'b0, 0, 0, 0);
      check_res("R9 positive clamp", 8388607, 0, 16500);

      // R9: negative saturation
      sample_valid = 1'b1;
      ry_in = -9'sd256; by_in = 9'sd255; luma_in = 8'd100;
      repeat (16500) @(posedge clk);
      @(negedge clk);
      sample_valid = 1'b0;
      step(1'b1, 1'b0, 0, 0, 0);
      check_res("R9 negative clamp", -8388608, 0, 16500);

      // R1: reset during operation clears results
      rst_n = 1'b0;
      @(negedge clk);
      check_res("R1 mid reset", 0, 0, 0);
      rst_n = 1'b1;

      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule